// File: doc/BRIEF.md
# Victim Line Store with Writeback Queue

This block sits beside a set-associative L1 cache and keeps a handful of recently evicted lines in fully associative slots. Any line may occupy any slot, regardless of the L1 set it came from. The store therefore acts as an extra way that any set can borrow. It covers several overflowing sets at once, provided the total overflow fits in the slot count. A line that keeps being pushed out of an over-subscribed set is still found here when the L1 misses on it again.

The same slots also hold dirty evictions that still have to reach the next memory level. Dirty slots are offered on a drain port with a valid/ready handshake. They go out oldest first, and the next level may stall the port for as long as it likes. A dirty line stays visible to lookups until it has been written back.

On an L1 miss, the cache presents the full line address on the lookup port. The answer comes back in the same cycle. On a hit, the line returns to the L1 together with its dirty status, and its slot is freed at the next clock edge. The L1 offers evicted lines on the insert port. A free slot is used first; failing that, the oldest clean line is overwritten. When every slot holds an undrained dirty line, the insert port refuses new lines until a drain completes.

Top module: `victim_buffer`

## Requirements
- R1: After reset no slot is occupied: a lookup misses, `dr_valid` is 0 and `ins_ready` is 1.
- R2: When `lk_valid` is 1 and `lk_addr` equals the address of an occupied slot, `lk_hit` is 1 and `lk_data` carries that slot's data in the same cycle, with no register in between.
- R3: A lookup hit frees the slot at the next clock edge, so a later lookup of the same address misses.
- R4: `lk_dirty` is 1 on a hit exactly when the slot is dirty and its write to the next level has not completed. A slot whose drain handshake has completed stays occupied and hittable with `lk_dirty` 0.
- R5: `dr_valid` is 1 whenever at least one occupied slot is dirty. `dr_addr` and `dr_data` then show the dirty slot that was inserted earliest, so dirty lines drain in insertion order.
- R6: While `dr_valid` is 1 and `dr_ready` is 0, the offered line stays the same in the next cycle. The only exception is a lookup hit on that very line, which takes it back.
- R7: `ins_ready` is 0 exactly when every slot is occupied and dirty. It returns to 1 in the cycle after a drain handshake or a lookup hit frees up such a slot.
- R8: An accepted insert fills a free slot if one exists. Otherwise it overwrites the oldest clean line, which then misses on lookup.
- R9: When a lookup hit and a drain handshake hit the same slot in one cycle, `lk_dirty` is 0 and the line leaves the store.
- R10: A lookup hit on an undrained dirty line removes it from the drain order, so that line is never offered on the drain port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request from an L1 miss |
| lk_addr | input | LINE_AW | Line address to search |
| lk_hit | output | 1 | Line found in the store |
| lk_data | output | LINE_DW | Data of the found line |
| lk_dirty | output | 1 | Found line still owes a writeback |
| ins_valid | input | 1 | Evicted line offered by the L1 |
| ins_ready | output | 1 | A slot can take the offered line |
| ins_addr | input | LINE_AW | Address of the evicted line |
| ins_data | input | LINE_DW | Data of the evicted line |
| ins_dirty | input | 1 | Evicted line is modified |
| dr_valid | output | 1 | A dirty line is offered to the next level |
| dr_ready | input | 1 | Next level accepts the offered line |
| dr_addr | output | LINE_AW | Address of the offered line |
| dr_data | output | LINE_DW | Data of the offered line |

## Verification
The interesting collision is between a lookup that takes a line back and the drain handshake that writes that same line out in the same cycle. The dirty flag returned to the L1 must then already be clear, and the line must vanish from both roles. The directed part provokes this by raising `dr_ready` while looking up the address currently shown on `dr_addr`. The random part lets lookups, inserts and stalled or accepted drains coincide freely over a small address pool, so that such overlaps recur. Each cycle, a slot-level model in the bench predicts the hit, the returned dirty flag, the offered drain line and the insert readiness, and those predictions are compared with the ports just before the clock edge.

// File: rtl/vb_pkg.sv
// Shared types for the victim line store.
package vb_pkg;
    // Where an accepted insert lands.
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_CLEAN = 2'd1,
        SLOT_NONE  = 2'd2
    } alloc_kind_e;
endpackage

// File: rtl/vb_match.sv
// Fully associative address compare across all slots.
// Assumes no two occupied slots hold the same address (the L1 never
// evicts a line that is already held here).
module vb_match #(
    parameter int SLOTS   = 4,
    parameter int LINE_AW = 16,
    localparam int IW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLOTS-1:0]   ent_valid,
    input  logic [LINE_AW-1:0] ent_addr [SLOTS],
    input  logic [LINE_AW-1:0] key,
    output logic [SLOTS-1:0]   hit_vec,
    output logic [IW-1:0]      hit_idx,
    output logic               any_hit
);
    // One comparator per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g] && (ent_addr[g] == key);
    end

    // Encode the matching slot index.
    always_comb begin : p_encode
        hit_idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end

    assign any_hit = |hit_vec;

    // R2: an address is held in at most one slot
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/vb_age_matrix.sv
// Pairwise insertion-order matrix: older_o[i][j] is 1 when slot i was filled
// before slot j. Assumes at most one slot is filled per cycle.
module vb_age_matrix #(
    parameter int SLOTS = 4,
    localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [IW-1:0]    ins_slot,
    output logic [SLOTS-1:0] older_o [SLOTS]
);
    // Newest slot becomes younger than every other slot.
    always_ff @(posedge clk) begin : p_age
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++)
                for (int j = 0; j < SLOTS; j++)
                    older_o[i][j] <= (i < j);
        end else if (ins_en) begin
            for (int j = 0; j < SLOTS; j++) begin
                older_o[ins_slot][j] <= 1'b0;
                older_o[j][ins_slot] <= (j != int'(ins_slot));
            end
        end
    end
endmodule

// File: rtl/vb_oldest.sv
// Picks the earliest-filled slot among those set in a mask, using the age
// matrix. Assumes the matrix is a strict total order.
module vb_oldest #(
    parameter int SLOTS = 4,
    localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0] older [SLOTS],
    input  logic [SLOTS-1:0] mask,
    output logic             any,
    output logic [IW-1:0]    idx
);
    logic [SLOTS-1:0] sel;

    // A candidate wins when no other masked slot is older than it.
    always_comb begin : p_pick
        logic cand;
        sel = '0;
        idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            cand = mask[i];
            for (int j = 0; j < SLOTS; j++) begin
                if (j != i && mask[j] && older[j][i]) cand = 1'b0;
            end
            sel[i] = cand;
        end
        for (int i = 0; i < SLOTS; i++) begin
            if (sel[i]) idx = IW'(i);
        end
    end

    assign any = |mask;
endmodule

// File: rtl/victim_buffer.sv
// Victim line store with an integrated writeback queue.
// Holds SLOTS fully associative lines evicted from an L1. Lookups answer in
// the same cycle and free the slot on a hit. Dirty lines drain oldest first
// through a valid/ready port. Inserts take a free slot, else the oldest clean
// line. Assumes the L1 never inserts an address already held here, nor the
// address it is looking up in that cycle.
module victim_buffer #(
    parameter int LINE_AW = 16,
    parameter int LINE_DW = 32,
    parameter int SLOTS   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [LINE_AW-1:0] lk_addr,
    output logic               lk_hit,
    output logic [LINE_DW-1:0] lk_data,
    output logic               lk_dirty,
    input  logic               ins_valid,
    output logic               ins_ready,
    input  logic [LINE_AW-1:0] ins_addr,
    input  logic [LINE_DW-1:0] ins_data,
    input  logic               ins_dirty,
    output logic               dr_valid,
    input  logic               dr_ready,
    output logic [LINE_AW-1:0] dr_addr,
    output logic [LINE_DW-1:0] dr_data
);
    import vb_pkg::*;

    localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [SLOTS-1:0]   valid_q;
    logic [SLOTS-1:0]   dirty_q;
    logic [LINE_AW-1:0] addr_q [SLOTS];
    logic [LINE_DW-1:0] data_q [SLOTS];
    logic [SLOTS-1:0]   older [SLOTS];

    logic [SLOTS-1:0] hit_vec;
    logic [IW-1:0]    hit_idx;
    logic             any_hit;
    logic             dr_any, clean_any, free_any;
    logic [IW-1:0]    dr_idx, clean_idx, free_idx, ins_slot;
    logic             dr_fire, ins_fire;
    alloc_kind_e      kind;

    vb_match #(.SLOTS(SLOTS), .LINE_AW(LINE_AW)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .ent_valid(valid_q),
        .ent_addr (addr_q),
        .key      (lk_addr),
        .hit_vec  (hit_vec),
        .hit_idx  (hit_idx),
        .any_hit  (any_hit)
    );

    vb_age_matrix #(.SLOTS(SLOTS)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .ins_en  (ins_fire),
        .ins_slot(ins_slot),
        .older_o (older)
    );

    vb_oldest #(.SLOTS(SLOTS)) u_old_dirty (
        .older(older),
        .mask (valid_q & dirty_q),
        .any  (dr_any),
        .idx  (dr_idx)
    );

    vb_oldest #(.SLOTS(SLOTS)) u_old_clean (
        .older(older),
        .mask (valid_q & ~dirty_q),
        .any  (clean_any),
        .idx  (clean_idx)
    );

    // Lookup response, valid in the request cycle.
    assign lk_hit   = lk_valid && any_hit;
    assign lk_data  = data_q[hit_idx];
    assign lk_dirty = lk_hit && dirty_q[hit_idx] && !(dr_fire && dr_idx == hit_idx);

    // Drain port shows the earliest dirty slot.
    assign dr_valid = dr_any;
    assign dr_addr  = addr_q[dr_idx];
    assign dr_data  = data_q[dr_idx];
    assign dr_fire  = dr_valid && dr_ready;

    // Lowest-numbered empty slot.
    always_comb begin : p_free
        free_any = !(&valid_q);
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!valid_q[i]) free_idx = IW'(i);
        end
    end

    // Insert target: empty slot first, then oldest clean line.
    always_comb begin : p_alloc
        if (free_any) begin
            kind     = SLOT_FREE;
            ins_slot = free_idx;
        end else if (clean_any) begin
            kind     = SLOT_CLEAN;
            ins_slot = clean_idx;
        end else begin
            kind     = SLOT_NONE;
            ins_slot = free_idx;
        end
    end

    assign ins_ready = (kind != SLOT_NONE);
    assign ins_fire  = ins_valid && ins_ready;

    // Slot state: a fill wins, otherwise a hit frees and a drain cleans.
    always_ff @(posedge clk) begin : p_slots
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (ins_fire && ins_slot == IW'(i)) begin
                    valid_q[i] <= 1'b1;
                    dirty_q[i] <= ins_dirty;
                    addr_q[i]  <= ins_addr;
                    data_q[i]  <= ins_data;
                end else if (lk_hit && hit_idx == IW'(i)) begin
                    valid_q[i] <= 1'b0;
                    dirty_q[i] <= 1'b0;
                end else if (dr_fire && dr_idx == IW'(i)) begin
                    dirty_q[i] <= 1'b0;
                end
            end
        end
    end

    // R6: a stalled drain offer holds unless the lookup takes it back
    a_r6_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid && !dr_ready && !(lk_valid && lk_addr == dr_addr)
        |=> dr_valid && $stable(dr_addr) && $stable(dr_data));

    // R7: a refused insert always has a pending drain to wait on
    a_r7_block_has_drain: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_ready |-> dr_valid);

    // R4: a line returned dirty is still queued for writeback
    a_r4_dirty_queued: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit && lk_dirty |-> dr_valid);

    // R9: a drain completing on the looked-up line returns it clean
    a_r9_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit && dr_valid && dr_ready && lk_addr == dr_addr |-> !lk_dirty);

    // R3: a hit line is gone in the next cycle
    a_r3_hit_frees: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit && !(ins_valid && ins_ready && ins_addr == lk_addr)
        |=> !(lk_hit && lk_addr == $past(lk_addr)));
endmodule

// File: tb/sim_victim_buffer.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a slot-level model kept in the bench.
module sim_victim_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0, ins_valid = 1'b0, ins_dirty = 1'b0, dr_ready = 1'b0;
    logic [AW-1:0] lk_addr = '0, ins_addr = '0;
    logic [DW-1:0] ins_data = '0;
    logic lk_hit, lk_dirty, ins_ready, dr_valid;
    logic [DW-1:0] lk_data, dr_data;
    logic [AW-1:0] dr_addr;

    int errors = 0;
    int checks = 0;

    // model state
    bit            m_valid [N];
    bit            m_dirty [N];
    logic [AW-1:0] m_addr  [N];
    logic [DW-1:0] m_data  [N];
    int            m_stamp [N];
    int            stamp_ctr = 0;

    // outputs captured in the last step
    logic o_hit, o_dirty, o_drv, o_rdy;
    logic [AW-1:0] o_dra;

    always #(CLK_PERIOD / 2) clk = ~clk;

    victim_buffer #(.LINE_AW(AW), .LINE_DW(DW), .SLOTS(N)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
        .lk_data(lk_data), .lk_dirty(lk_dirty),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_addr(ins_addr),
        .ins_data(ins_data), .ins_dirty(ins_dirty),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_data(dr_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic int m_oldest(input bit want_dirty);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_dirty[i] == want_dirty && (best < 0 || m_stamp[i] < m_stamp[best]))
                best = i;
        return best;
    endfunction

    function automatic int m_slot();
        for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
        return m_oldest(1'b0);
    endfunction

    function automatic logic [AW-1:0] pick_new(input logic [AW-1:0] avoid);
        int start = int'($urandom % 16);
        for (int k = 0; k < 16; k++) begin
            logic [AW-1:0] a = AW'(16'h0100 + ((start + k) % 16));
            if (m_find(a) < 0 && a != avoid) return a;
        end
        return 16'h0fff;
    endfunction

    // One cycle: drive, compare with model just before the edge, update model.
    task automatic step(input bit lkv, input logic [AW-1:0] lka, input bit insv,
                        input logic [AW-1:0] insa, input logic [DW-1:0] insd,
                        input bit insdt, input bit drr);
        int h, d, s;
        bit exp_dirty, drf, rdy;
        @(negedge clk);
        lk_valid = lkv; lk_addr = lka; ins_valid = insv; ins_addr = insa;
        ins_data = insd; ins_dirty = insdt; dr_ready = drr;
        #1;
        h   = lkv ? m_find(lka) : -1;
        d   = m_oldest(1'b1);
        s   = m_slot();
        rdy = (s >= 0);
        drf = (d >= 0) && drr;
        exp_dirty = (h >= 0) && m_dirty[h] && !(drf && d == h);
        check("R2 R3 lk_hit", 64'(lk_hit), 64'(h >= 0));
        if (h >= 0) check("R2 lk_data", 64'(lk_data), 64'(m_data[h]));
        check("R4 lk_dirty", 64'(lk_dirty), 64'(exp_dirty));
        check("R5 dr_valid", 64'(dr_valid), 64'(d >= 0));
        if (d >= 0) begin
            check("R5 dr_addr", 64'(dr_addr), 64'(m_addr[d]));
            check("R5 dr_data", 64'(dr_data), 64'(m_data[d]));
        end
        check("R7 ins_ready", 64'(ins_ready), 64'(rdy));
        o_hit = lk_hit; o_dirty = lk_dirty; o_drv = dr_valid; o_rdy = ins_ready; o_dra = dr_addr;
        if (drf) m_dirty[d] = 1'b0;
        if (h >= 0) begin m_valid[h] = 1'b0; m_dirty[h] = 1'b0; end
        if (insv && rdy) begin
            m_valid[s] = 1'b1; m_dirty[s] = insdt; m_addr[s] = insa;
            m_data[s] = insd; m_stamp[s] = stamp_ctr; stamp_ctr++;
        end
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = int'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_dirty[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        step(1, 16'h0201, 0, '0, '0, 0, 0);
        check("R1 hit", 64'(o_hit), 64'd0);
        check("R1 dr_valid", 64'(o_drv), 64'd0);
        check("R1 ins_ready", 64'(o_rdy), 64'd1);

        // fill every slot with dirty lines while the drain is stalled
        for (int k = 1; k <= 4; k++) step(0, '0, 1, AW'(16'h0200 + k), DW'(32'hd000 + k), 1, 0);
        step(0, '0, 0, '0, '0, 0, 0);
        check("R7 full dirty blocks", 64'(o_rdy), 64'd0);
        check("R6 stalled offer", 64'(o_dra), 64'h0201);
        step(0, '0, 1, 16'h0299, 32'h1, 0, 0);
        check("R6 stalled offer holds", 64'(o_dra), 64'h0201);

        // R10: take back an undrained dirty line
        step(1, 16'h0202, 0, '0, '0, 0, 0);
        check("R10 returned dirty", 64'(o_dirty), 64'd1);

        // R9: lookup and drain on the same line in one cycle
        step(1, 16'h0201, 0, '0, '0, 0, 1);
        check("R9 hit", 64'(o_hit), 64'd1);
        check("R9 dirty cleared", 64'(o_dirty), 64'd0);
        step(0, '0, 0, '0, '0, 0, 0);
        check("R10 skipped line", 64'(o_dra), 64'h0203);

        // drain the rest, drained lines stay hittable and clean
        step(0, '0, 0, '0, '0, 0, 1);
        step(0, '0, 0, '0, '0, 0, 1);
        step(0, '0, 0, '0, '0, 0, 0);
        check("R5 queue empty", 64'(o_drv), 64'd0);
        step(1, 16'h0203, 0, '0, '0, 0, 0);
        check("R4 drained hit", 64'(o_hit), 64'd1);
        check("R4 drained clean", 64'(o_dirty), 64'd0);

        // R8: overwrite the oldest clean line once full
        for (int k = 5; k <= 7; k++) step(0, '0, 1, AW'(16'h0200 + k), DW'(32'hc000 + k), 0, 0);
        step(0, '0, 1, 16'h0208, 32'hc008, 0, 0);
        check("R8 clean full accepts", 64'(o_rdy), 64'd1);
        step(1, 16'h0204, 0, '0, '0, 0, 0);
        check("R8 oldest clean dropped", 64'(o_hit), 64'd0);
        step(1, 16'h0205, 0, '0, '0, 0, 0);
        check("R8 younger kept", 64'(o_hit), 64'd1);

        // seeded random traffic over a small address pool
        for (int c = 0; c < 3000; c++) begin
            logic [AW-1:0] la;
            bit lv;
            lv = ($urandom % 2) == 0;
            la = AW'(16'h0100 + ($urandom % 16));
            if (lv && m_find(la) < 0 && ($urandom % 2) == 0) begin
                for (int i = 0; i < N; i++) if (m_valid[i]) la = m_addr[i];
            end
            step(lv, la, ($urandom % 3) != 0, pick_new(lv ? la : 16'hffff),
                 $urandom, ($urandom % 2) == 0, ($urandom % 4) != 0);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule